// File: doc/BRIEF.md
# RAM-Based Slow Delay Line

This block holds back a narrow data word, such as a three-bit colour code, for a long time. It does not use a long shift register. It keeps the samples in a small circular RAM and steps through that RAM only once per sample period. A prescaler defines the sample period as `TICK_CYCLES` clock cycles.

The block writes the input into the current location on every clock cycle. Within one period, each cycle overwrites the value written in the cycle before. The read address is always the location just after the write address, modulo `DEPTH`. That location is the oldest one in the ring. The output therefore shows what was written about `(DEPTH-1)` sample periods earlier.

The delay can be resolved only to one sample period. As an example, 1000 locations with a 200 000-cycle period at 100 MHz give about two seconds of delay in 2 ms steps. Until the ring has been filled once after reset, the output is unspecified.

Top module: `slow_delay_line`

## Requirements
- R1: The output word has the same width (`DATA_W`, default 3) and bit order as the input word. Every code value passes through unchanged.
- R2: `rst` is a synchronous, active-high reset. At the first rising edge with `rst` high, `dout` becomes 0. While `rst` stays high, `dout` stays 0 whatever `din` does.
- R3: The read location is always one past the write location, modulo `DEPTH`.
- R4: Reset clears the prescaler and both pointers. Both pointers then advance once every `TICK_CYCLES` cycles, on the same edge. Counting the first rising edge with `rst` low as edge 1, the write location is 0 for edges 1 to `TICK_CYCLES`.
- R5: The write port is enabled on every clock cycle. The value stored for a sample period is the input present at the last edge of that period.
- R6: A step change on `din` that is held long enough reaches `dout` between `(DEPTH-2)*TICK_CYCLES` and `DEPTH*TICK_CYCLES` cycles after the change.
- R7: Take a value driven before edge 1 after reset and held through edge `TICK_CYCLES`. It appears on `dout` after edge `(DEPTH-1)*TICK_CYCLES+1`.
- R8: Once a held value has reached `dout`, `dout` stays at that value until the next input change has travelled through. Before that, `dout` keeps the previous held value.
- R9: The pointers wrap from `DEPTH-1` back to 0, so operation continues for any number of periods.
- R10: The read port is registered and not transparent. Data appears one cycle after the read location is selected, so the value in R7 is still on `dout` after edge `DEPTH*TICK_CYCLES`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | DATA_W | Word to be delayed |
| dout | output | DATA_W | Delayed word (registered) |

## Verification
Suppose the read pointer drifts from its place just ahead of the write pointer. The delay then shrinks or grows by whole sample periods, and the step-response latency leaves its window on the very next value change. A prescaler that counts wrongly, or that is not cleared by reset, shifts the exact post-reset arrival edge. That shift is visible within `DEPTH` periods of reset. A pointer that fails to wrap makes the held output break up into stale or mixed values within one trip around the ring.

// File: rtl/sdl_pkg.sv
package sdl_pkg;

  // Bits needed to count 0 .. n-1, never less than one.
  function automatic int unsigned width_for(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/sdl_tick_gen.sv
module sdl_tick_gen #(
  parameter int unsigned TICK_CYCLES = 10
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned CW = sdl_pkg::width_for(TICK_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);

  // R4: the prescaler never leaves its range
  assert_cnt_range_R4: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);

  // R4: a tick is never followed by another one when the period exceeds one cycle
  assert_tick_gap_R4: assert property (@(posedge clk) disable iff (rst)
    (tick && (TICK_CYCLES > 1)) |=> !tick);

endmodule

// File: rtl/sdl_ring_ptr.sv
module sdl_ring_ptr #(
  parameter int unsigned DEPTH = 5,
  localparam int unsigned AW = sdl_pkg::width_for(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr
);
  localparam logic [AW-1:0] TOP    = AW'(DEPTH - 1);
  localparam logic [AW-1:0] RD_INI = AW'(1 % DEPTH);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_addr <= '0;
      rd_addr <= RD_INI;
    end else if (adv) begin
      wr_addr <= (wr_addr == TOP) ? '0 : wr_addr + 1'b1;
      rd_addr <= (rd_addr == TOP) ? '0 : rd_addr + 1'b1;
    end
  end

  // R3: the read location stays one past the write location
  assert_rd_ahead_R3: assert property (@(posedge clk) disable iff (rst)
    rd_addr == ((wr_addr == TOP) ? '0 : wr_addr + 1'b1));

  // R4: without a tick, neither pointer moves
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !adv |=> ($stable(wr_addr) && $stable(rd_addr)));

  // R9: the write pointer stays within the ring
  assert_bound_R9: assert property (@(posedge clk) disable iff (rst)
    wr_addr <= TOP);

  // R9: stepping from the last location returns to zero
  assert_wrap_R9: assert property (@(posedge clk) disable iff (rst)
    (adv && wr_addr == TOP) |=> wr_addr == '0);

endmodule

// File: rtl/sdl_ring_ram.sv
module sdl_ring_ram #(
  parameter int unsigned DATA_W = 3,
  parameter int unsigned DEPTH  = 5,
  localparam int unsigned AW = sdl_pkg::width_for(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  // Write port: always enabled.
  always_ff @(posedge clk) begin
    mem[wr_addr] <= wr_data;
  end

  // Read port: registered, old data on a collision, resettable output register.
  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/slow_delay_line.sv
module slow_delay_line #(
  parameter int unsigned DATA_W      = 3,
  parameter int unsigned DEPTH       = 1000,
  parameter int unsigned TICK_CYCLES = 200000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam int unsigned AW = sdl_pkg::width_for(DEPTH);

  logic          tick;
  logic [AW-1:0] wr_addr;
  logic [AW-1:0] rd_addr;

  sdl_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  sdl_ring_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk     (clk),
    .rst     (rst),
    .adv     (tick),
    .wr_addr (wr_addr),
    .rd_addr (rd_addr)
  );

  sdl_ring_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk     (clk),
    .rst     (rst),
    .wr_addr (wr_addr),
    .wr_data (din),
    .rd_addr (rd_addr),
    .rd_data (dout)
  );

  // R2: one cycle after a reset cycle, the output is clear
  assert_out_clear_R2: assert property (@(posedge clk)
    $past(rst) |-> dout == '0);

endmodule

// File: tb/test_slow_delay_line.sv
module test_slow_delay_line;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 3;
  localparam int D  = 5;
  localparam int T  = 10;
  localparam int LAT_MIN = (D - 2) * T;
  localparam int LAT_MAX = D * T;

  typedef struct packed {
    logic [2:0] val;
    logic [7:0] hold;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{3'd3, 8'd55}, '{3'd6, 8'd60}, '{3'd1, 8'd57}, '{3'd7, 8'd63},
    '{3'd0, 8'd58}, '{3'd4, 8'd61}, '{3'd2, 8'd56}, '{3'd5, 8'd64}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;

  int n_run  = 0;
  int n_fail = 0;

  slow_delay_line #(.DATA_W(DW), .DEPTH(D), .TICK_CYCLES(T)) i_slow_delay_line (
    .clk  (clk),
    .rst  (rst),
    .din  (din),
    .dout (dout)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called at a negedge with rst high. Releases reset and checks exact timing.
  task automatic run_align(input logic [DW-1:0] v, input logic [DW-1:0] w);
    rst = 1'b0;
    din = v;
    for (int e = 1; e <= (D + 1) * T; e++) begin
      @(negedge clk);
      if (e == T) din = w;  // R5: last write of period 0 is v
      if (e == (D - 1) * T + 1) chk(dout == v, "R7", int'(dout), int'(v));
      if (e == D * T)           chk(dout == v, "R10", int'(dout), int'(v));
      if (e == D * T + 1)       chk(dout == w, "R3 R4", int'(dout), int'(w));
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    logic [DW-1:0] prev;
    // R2: output clear during initial reset
    repeat (4) @(negedge clk);
    chk(dout == '0, "R2", int'(dout), 0);

    run_align(3'd5, 3'd2);
    prev = 3'd2;

    // Table of held values: R1 R6 R8 R9 (runs many trips round the ring)
    for (int i = 0; i < 8; i++) begin
      int  lat;
      int  early;
      int  unstable;
      bit  arrived;
      lat = 0; early = 0; unstable = 0; arrived = 1'b0;
      din = VECS[i].val;
      for (int c = 1; c <= int'(VECS[i].hold); c++) begin
        @(negedge clk);
        if (!arrived) begin
          if (dout == VECS[i].val) begin
            arrived = 1'b1;
            lat = c;
          end else if (dout != prev) begin
            early++;
          end
        end else if (dout != VECS[i].val) begin
          unstable++;
        end
      end
      chk(arrived && lat >= LAT_MIN && lat <= LAT_MAX, "R6 R1 R9", lat, (D - 1) * T);
      chk(early == 0 && unstable == 0, "R8", early + unstable, 0);
      prev = VECS[i].val;
    end

    // R2: reset in mid-run clears output and holds it clear
    rst = 1'b1;
    for (int k = 0; k < 3; k++) begin
      din = 3'(k + 3);
      @(negedge clk);
      chk(dout == '0, "R2", int'(dout), 0);
    end
    // R4: prescaler and pointers were cleared by that reset
    run_align(3'd6, 3'd1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule